// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Sequencer

This block is the timing core of a master-only SPI controller. It makes the serial clock from the system clock and drives a vector of chip-select lines. A shift engine asks it for a frame by raising a start pulse together with a bit count. In return it gets one-cycle strobes that say when to sample the incoming bit and when to present the next outgoing bit. The block does not move data, buffer it or decode a bus.

Configuration reaches the block as plain inputs: clock divisor, polarity, phase, chip-select index and chip-select mode. Two delay words and the chip-select inactive-level word are held inside and loaded through write strobes. The inactive-level word reads back only the bits of lines that exist, so software can count the lines by writing all ones and reading back the result. Three chip-select behaviours are supported. The line can pulse around every frame, stay asserted across frames, or never assert at all. Four delays, counted in SCK periods, shape the time around chip-select edges and between frames.

Top module: `spi_sck_cs_seq`

## Requirements
- R1: After reset, sck is 0, busy is 0, every line sits at its inactive level, and the inactive-level word reads back as all ones over the implemented lines (0xF for 4 lines).
- R2: A write of the inactive-level word with wr_csdef stores only the low CS_LINES bits of wr_data, and csdef_rd returns them zero-extended. An idle line drives its stored bit. A selected active line drives the complement of that bit, and at most one line is ever active.
- R3: While no frame is in progress, sck follows cfg_cpol one clock later.
- R4: Let H = cfg_div + 1. A frame of L bits (frame_len, 1 to 15) makes exactly 2·L SCK edges, spaced H clocks apart. The first edge moves sck away from its idle level.
- R5: sample_stb and shift_stb each pulse L times per frame, in the clock just before an SCK edge. With cfg_cpha = 0, sample_stb marks the leading edges (sck still at idle) and shift_stb marks the trailing edges. With cfg_cpha = 1 the roles swap.
- R6: In auto mode (cfg_csmode 0, and code 1 acts the same), the selected line goes active right after the clock edge that accepts the start. The first SCK edge comes (2·C+1)·H+1 clocks later, where C is the cs-to-sck delay. The line returns inactive 2·S·H+2 clocks after the last SCK edge, where S is the sck-to-cs delay.
- R7: After a line returns inactive, busy stays high for 2·G·H+1 further clocks, where G is the inter-CS delay. A start request that arrives while busy is high is dropped.
- R8: wr_dly0 loads cs-to-sck from wr_data[7:0] and sck-to-cs from wr_data[23:16]. wr_dly1 loads inter-CS from wr_data[7:0] and inter-transfer from wr_data[23:16]. Reset values are 1, 1, 1 and 0.
- R9: In hold mode (cfg_csmode 2), the line stays active after the frame, and busy falls one clock after the last SCK edge. A following frame to the same line leaves it active, and its first SCK edge comes (2·X+1)·H+1 clocks after acceptance, where X is the inter-transfer delay.
- R10: While a line is held and no frame is running, any of these releases it on the next clock: a change of mode away from hold, a change of cfg_csid, or a write of the inactive-level word. The inter-CS wait of R7 then follows.
- R11: In off mode (cfg_csmode 3), no line ever leaves its inactive level, and SCK still runs the frame.
- R12: cfg_div, cfg_cpol and cfg_cpha are captured only while idle. A change made during a frame does not alter that frame's timing.
- R13: A start request with frame_len 0 is ignored. busy stays low and sck does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | DIV_W | Half-period divisor; half period is cfg_div+1 clocks |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_csmode | input | 2 | 0/1 auto, 2 hold, 3 off |
| cfg_csid | input | 5 | Index of the line to drive |
| wr_dly0 | input | 1 | Load cs-to-sck and sck-to-cs delays from wr_data |
| wr_dly1 | input | 1 | Load inter-CS and inter-transfer delays from wr_data |
| wr_csdef | input | 1 | Load inactive-level word from wr_data |
| wr_data | input | 32 | Write data for the three strobes |
| csdef_rd | output | 32 | Inactive-level word, implemented bits only |
| frame_start | input | 1 | Frame request, accepted while busy is low |
| frame_len | input | LEN_W | Bits in the requested frame |
| busy | output | 1 | High while a frame or a chip-select wait is in progress |
| sck | output | 1 | Serial clock |
| cs_line | output | CS_LINES | Chip-select lines |
| sample_stb | output | 1 | Next SCK edge is a sampling edge |
| shift_stb | output | 1 | Next SCK edge is a shifting edge |

## Verification
Auto-mode frames are run with four settings. Each one has a different divisor, polarity, phase, length and set of delays. A fixed offset or a mix-up between the leading and trailing delays would show at a different edge time for each setting. Zero delays and one-bit frames are in the mix, so the one-clock state-change overhead is pinned down separately from the multiplied part. Hold-mode frames are run back to back and then released three ways: by mode, by index and by word write. These runs tell the inter-transfer path apart from the chip-select assert path. Off-mode frames, zero-length requests and a divisor change in mid-frame show that those inputs leave the line and clock timing alone.

// File: rtl/spi_sck_cs_seq.sv
module spi_sck_cs_seq #(
  parameter int CS_LINES = 4,
  parameter int DIV_W    = 12,
  parameter int DLY_W    = 8,
  parameter int LEN_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIV_W-1:0]    cfg_div,
  input  logic                cfg_cpha,
  input  logic                cfg_cpol,
  input  logic [1:0]          cfg_csmode,
  input  logic [4:0]          cfg_csid,
  input  logic                wr_dly0,
  input  logic                wr_dly1,
  input  logic                wr_csdef,
  input  logic [31:0]         wr_data,
  output logic [31:0]         csdef_rd,
  input  logic                frame_start,
  input  logic [LEN_W-1:0]    frame_len,
  output logic                busy,
  output logic                sck,
  output logic [CS_LINES-1:0] cs_line,
  output logic                sample_stb,
  output logic                shift_stb
);
  localparam int REM_W = ((DLY_W > LEN_W) ? DLY_W : LEN_W) + 1;
  localparam logic [1:0] MODE_HOLD = 2'd2;
  localparam logic [1:0] MODE_OFF  = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_IXF, S_LEAD, S_XFER, S_TRAIL, S_GAP} st_t;

  st_t                 st;
  logic [REM_W-1:0]    rem;
  logic [DIV_W-1:0]    divcnt, div_a;
  logic                cpol_a, cpha_a, hold_l, cs_act, sck_r;
  logic [4:0]          csid_l;
  logic [LEN_W-1:0]    len_l;
  logic [CS_LINES-1:0] csdef;
  logic [DLY_W-1:0]    d_cssck, d_sckcs, d_intercs, d_interxfr;

  function automatic logic [REM_W-1:0] twice(input logic [DLY_W-1:0] d);
    return REM_W'({d, 1'b0});
  endfunction

  wire ht      = (divcnt == div_a);
  wire release_hold = (st == S_IDLE) && cs_act &&
                      ((cfg_csmode != MODE_HOLD) || (cfg_csid != csid_l) || wr_csdef);
  wire go      = (st == S_IDLE) && !release_hold && frame_start && (frame_len != '0);
  wire edge_now = (st == S_XFER) && ht && (rem != '0);
  wire lead    = ~rem[0];

  assign busy       = (st != S_IDLE);
  assign sck        = sck_r;
  assign sample_stb = edge_now && (lead ^ cpha_a);
  assign shift_stb  = edge_now && !(lead ^ cpha_a);
  assign csdef_rd   = 32'(csdef);

  for (genvar i = 0; i < CS_LINES; i++) begin : g_cs
    assign cs_line[i] = csdef[i] ^ (cs_act && (csid_l == 5'(i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_cssck    <= DLY_W'(1);
      d_sckcs    <= DLY_W'(1);
      d_intercs  <= DLY_W'(1);
      d_interxfr <= '0;
      csdef      <= '1;
    end else begin
      if (wr_dly0) begin
        d_cssck <= wr_data[DLY_W-1:0];
        d_sckcs <= wr_data[16 +: DLY_W];
      end
      if (wr_dly1) begin
        d_intercs  <= wr_data[DLY_W-1:0];
        d_interxfr <= wr_data[16 +: DLY_W];
      end
      if (wr_csdef) csdef <= wr_data[CS_LINES-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      rem    <= '0;
      divcnt <= '0;
      div_a  <= '0;
      cpol_a <= 1'b0;
      cpha_a <= 1'b0;
      hold_l <= 1'b0;
      cs_act <= 1'b0;
      csid_l <= '0;
      len_l  <= '0;
      sck_r  <= 1'b0;
    end else if (st == S_IDLE) begin
      divcnt <= '0;
      div_a  <= cfg_div;
      cpol_a <= cfg_cpol;
      cpha_a <= cfg_cpha;
      sck_r  <= cfg_cpol;
      if (release_hold) begin
        cs_act <= 1'b0;
        st     <= S_GAP;
        rem    <= twice(d_intercs);
      end else if (go) begin
        hold_l <= (cfg_csmode == MODE_HOLD);
        len_l  <= frame_len;
        if (cs_act) begin
          st  <= S_IXF;
          rem <= twice(d_interxfr);
        end else begin
          st     <= S_LEAD;
          rem    <= twice(d_cssck);
          cs_act <= (cfg_csmode != MODE_OFF);
          csid_l <= cfg_csid;
        end
      end
    end else if (rem == '0) begin
      divcnt <= '0;
      case (st)
        S_IXF, S_LEAD: begin
          st  <= S_XFER;
          rem <= REM_W'({len_l, 1'b0});
        end
        S_XFER: begin
          if (hold_l && cs_act) st <= S_IDLE;
          else begin
            st  <= S_TRAIL;
            rem <= twice(d_sckcs);
          end
        end
        S_TRAIL: begin
          cs_act <= 1'b0;
          st     <= S_GAP;
          rem    <= twice(d_intercs);
        end
        default: st <= S_IDLE;
      endcase
    end else if (ht) begin
      divcnt <= '0;
      rem    <= rem - 1'b1;
      if (st == S_XFER) sck_r <= ~sck_r;
    end else begin
      divcnt <= divcnt + 1'b1;
    end
  end
endmodule

module spi_sck_cs_seq_chk #(
  parameter int CS_LINES = 4,
  parameter int DIV_W    = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy,
  input logic                sck,
  input logic                cfg_cpol,
  input logic                cpol_a,
  input logic                cpha_a,
  input logic                cs_act,
  input logic                sample_stb,
  input logic                shift_stb,
  input logic [CS_LINES-1:0] cs_line,
  input logic [CS_LINES-1:0] csdef,
  input logic [DIV_W-1:0]    div_a
);
  assert_one_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_line ^ csdef));

  assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $past(rst_n)) |-> (sck == $past(cfg_cpol)));

  assert_sample_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> ((sck == cpol_a) != cpha_a));

  assert_shift_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |-> ((sck == cpol_a) == cpha_a));

  assert_cs_drop_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_act) |-> (sck == cpol_a));

  assert_div_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(div_a));
endmodule

bind spi_sck_cs_seq spi_sck_cs_seq_chk #(.CS_LINES(CS_LINES), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sck(sck), .cfg_cpol(cfg_cpol),
  .cpol_a(cpol_a), .cpha_a(cpha_a), .cs_act(cs_act), .sample_stb(sample_stb),
  .shift_stb(shift_stb), .cs_line(cs_line), .csdef(csdef), .div_a(div_a)
);

// File: tb/spi_sck_cs_seq_bench.sv
module spi_sck_cs_seq_bench;
  localparam int NL = 4;
  localparam int NV = 4;
  // div, cpol, cpha, len, cs-to-sck, sck-to-cs, inter-CS
  localparam logic [41:0] VEC [NV] = '{
    {12'd0, 1'b0, 1'b0, 4'd8,  8'd1, 8'd1, 8'd1},
    {12'd3, 1'b1, 1'b1, 4'd5,  8'd2, 8'd0, 8'd3},
    {12'd1, 1'b0, 1'b1, 4'd1,  8'd0, 8'd2, 8'd0},
    {12'd2, 1'b1, 1'b0, 4'd15, 8'd3, 8'd1, 8'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [11:0]   cfg_div = '0;
  logic          cfg_cpha = 1'b0, cfg_cpol = 1'b0;
  logic [1:0]    cfg_csmode = '0;
  logic [4:0]    cfg_csid = '0;
  logic          wr_dly0 = 1'b0, wr_dly1 = 1'b0, wr_csdef = 1'b0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   csdef_rd;
  logic          frame_start = 1'b0;
  logic [3:0]    frame_len = '0;
  logic          busy, sck, sample_stb, shift_stb;
  logic [NL-1:0] cs_line;

  spi_sck_cs_seq #(.CS_LINES(NL)) u_spi_sck_cs_seq (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_cpha(cfg_cpha), .cfg_cpol(cfg_cpol),
    .cfg_csmode(cfg_csmode), .cfg_csid(cfg_csid), .wr_dly0(wr_dly0), .wr_dly1(wr_dly1),
    .wr_csdef(wr_csdef), .wr_data(wr_data), .csdef_rd(csdef_rd), .frame_start(frame_start),
    .frame_len(frame_len), .busy(busy), .sck(sck), .cs_line(cs_line),
    .sample_stb(sample_stb), .shift_stb(shift_stb)
  );

  int checks = 0, fails = 0;
  int m_on, m_first, m_last, m_off, m_idle, m_edges, m_samp, m_shift, m_lead_samp;
  logic [NL-1:0] m_on_val;
  logic mid_en = 1'b0;
  logic [11:0] mid_div = '0;
  logic done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int f_first(int lead_d, int h);
    return (2 * lead_d + 1) * h + 1;
  endfunction
  function automatic int f_last(int lead_d, int l, int h);
    return 2 * lead_d * h + 1 + 2 * l * h;
  endfunction

  task automatic set_delays(input int c, input int s, input int g, input int x);
    @(negedge clk);
    wr_data = {8'd0, 8'(s), 8'd0, 8'(c)}; wr_dly0 = 1'b1;
    @(negedge clk);
    wr_dly0 = 1'b0; wr_data = {8'd0, 8'(x), 8'd0, 8'(g)}; wr_dly1 = 1'b1;
    @(negedge clk);
    wr_dly1 = 1'b0;
  endtask

  task automatic write_csdef(input logic [31:0] v);
    @(negedge clk);
    wr_data = v; wr_csdef = 1'b1;
    @(negedge clk);
    wr_csdef = 1'b0;
  endtask

  task automatic run_frame(input int len);
    logic psck;
    logic [NL-1:0] pcs;
    m_on = -1; m_first = -1; m_last = -1; m_off = -1; m_idle = -1;
    m_edges = 0; m_samp = 0; m_shift = 0; m_lead_samp = 0; m_on_val = '0;
    @(negedge clk);
    psck = sck; pcs = cs_line;
    frame_len = 4'(len); frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    if (mid_en) cfg_div = mid_div;
    for (int k = 0; k < 4000; k++) begin
      if (cs_line !== pcs) begin
        if (m_on < 0) begin m_on = k; m_on_val = cs_line; end
        else m_off = k;
      end
      if (sck !== psck) begin
        if (m_first < 0) m_first = k;
        m_last = k;
        m_edges++;
      end
      if (sample_stb) begin
        m_samp++;
        if (sck == cfg_cpol) m_lead_samp++;
      end
      if (shift_stb) m_shift++;
      psck = sck; pcs = cs_line;
      if (!busy) begin m_idle = k; break; end
      @(negedge clk);
    end
  endtask

  task automatic wait_idle(output int r);
    r = -1;
    for (int k = 0; k < 4000; k++) begin
      if (!busy) begin r = k; break; end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int r, h, c, s, g, l, e, bad;
    logic [NL-1:0] base;
    logic psck;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sck", sck, 0);
    chk("R1 busy", busy, 0);
    chk("R1 cs_line", cs_line, 4'hF);
    chk("R1 csdef_rd", csdef_rd, 32'hF);

    // R3 idle level follows polarity
    cfg_cpol = 1'b1;
    @(negedge clk);
    chk("R3 idle high", sck, 1);
    cfg_cpol = 1'b0;
    @(negedge clk);
    chk("R3 idle low", sck, 0);

    // R8 reset delays 1,1,1 with H=1, R6 auto frame
    run_frame(2);
    chk("R6 cs on", m_on, 0);
    chk("R6 cs on value", m_on_val, 4'hE);
    chk("R8 cs-to-sck default", m_first, f_first(1, 1));
    chk("R8 last edge", m_last, f_last(1, 2, 1));
    chk("R8 sck-to-cs default", m_off, f_last(1, 2, 1) + 4);
    chk("R8 inter-CS default", m_idle, f_last(1, 2, 1) + 4 + 3);

    // R2 inactive-level word
    write_csdef(32'hFFFF_FFFF);
    chk("R2 all-ones readback", csdef_rd, 32'hF);
    write_csdef(32'h0000_00FA);
    chk("R2 masked readback", csdef_rd, 32'hA);
    chk("R2 idle lines", cs_line, 4'hA);
    base = 4'hA;

    // table of auto-mode frames
    for (int v = 0; v < NV; v++) begin
      h = int'(VEC[v][41:30]) + 1;
      l = int'(VEC[v][27:24]);
      c = int'(VEC[v][23:16]);
      s = int'(VEC[v][15:8]);
      g = int'(VEC[v][7:0]);
      set_delays(c, s, g, 0);
      cfg_div = VEC[v][41:30]; cfg_cpol = VEC[v][29]; cfg_cpha = VEC[v][28];
      cfg_csmode = 2'd0; cfg_csid = 5'd0;
      repeat (2) @(negedge clk);
      run_frame(l);
      chk("R6 cs on", m_on, 0);
      chk("R6 cs on value", m_on_val, base ^ 4'h1);
      chk("R6 cs-to-sck", m_first, f_first(c, h));
      chk("R4 edge span", m_last - m_first, (2 * l - 1) * h);
      chk("R4 edge count", m_edges, 2 * l);
      chk("R6 sck-to-cs", m_off - m_last, 2 * s * h + 2);
      chk("R7 inter-CS", m_idle - m_off, 2 * g * h + 1);
      chk("R5 sample count", m_samp, l);
      chk("R5 shift count", m_shift, l);
      chk("R5 sample edge side", m_lead_samp, VEC[v][28] ? 0 : l);
    end

    // R12 divisor changed mid-frame
    set_delays(1, 1, 1, 0);
    cfg_div = 12'd0; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
    repeat (2) @(negedge clk);
    mid_en = 1'b1; mid_div = 12'd3;
    run_frame(4);
    mid_en = 1'b0; cfg_div = 12'd0;
    chk("R12 first edge", m_first, f_first(1, 1));
    chk("R12 last edge", m_last, f_last(1, 4, 1));
    repeat (2) @(negedge clk);

    // R7 start held high while busy: one frame only
    e = 0; r = 0;
    @(negedge clk);
    psck = sck;
    frame_len = 4'd1; frame_start = 1'b1;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (k == 2) frame_start = 1'b0;
      if (sck !== psck) e++;
      psck = sck;
    end
    chk("R7 start while busy dropped", e, 2);
    chk("R7 idle after", busy, 0);

    // R13 zero-length start ignored
    bad = 0;
    @(negedge clk);
    psck = sck;
    frame_len = 4'd0; frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    for (int k = 0; k < 6; k++) begin
      if (busy || sck !== psck) bad++;
      @(negedge clk);
    end
    chk("R13 zero length", bad, 0);

    // R9 hold mode
    set_delays(1, 1, 1, 2);
    cfg_div = 12'd1; cfg_csmode = 2'd2; cfg_csid = 5'd1;
    repeat (2) @(negedge clk);
    run_frame(3);
    chk("R9 cs on value", m_on_val, 4'h8);
    chk("R9 first edge", m_first, f_first(1, 2));
    chk("R9 busy fall", m_idle, f_last(1, 3, 2) + 1);
    chk("R9 no release", m_off, -1);
    @(negedge clk);
    chk("R9 held after frame", cs_line, 4'h8);
    run_frame(2);
    chk("R9 no re-assert", m_on, -1);
    chk("R9 inter-transfer", m_first, f_first(2, 2));
    chk("R9 busy fall 2", m_idle, f_last(2, 2, 2) + 1);

    // R10 release by mode change
    @(negedge clk);
    cfg_csmode = 2'd0;
    @(negedge clk);
    chk("R10 mode release line", cs_line, 4'hA);
    wait_idle(r);
    chk("R10 mode release gap", r, 5);

    // R10 release by index change
    cfg_csmode = 2'd2; cfg_csid = 5'd1;
    run_frame(1);
    @(negedge clk);
    cfg_csid = 5'd2;
    @(negedge clk);
    chk("R10 index release line", cs_line, 4'hA);
    wait_idle(r);
    chk("R10 index release gap", r, 5);

    // R10 release by inactive-level write
    run_frame(1);
    chk("R10 held index 2", cs_line, 4'hE);
    write_csdef(32'h0000_000A);
    chk("R10 write release line", cs_line, 4'hA);

    // R11 off mode
    wait_idle(r);
    cfg_csmode = 2'd3; cfg_csid = 5'd0;
    repeat (2) @(negedge clk);
    run_frame(2);
    chk("R11 no assert", m_on, -1);
    chk("R11 clock runs", m_edges, 4);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule